// File: doc/BRIEF.md
# Two-wire serial register loader

This block is a write-only target on a two-wire serial bus. It oversamples the clock and data lines with the system clock and filters out short glitches. It then recognises bus start and stop conditions and receives a fixed two-level address: first a device address byte, then a function byte that picks one of two 32-bit destination registers. The first is a closed-caption data word and the second is a control word. Four data bytes follow and are assembled most significant bit first. Every byte is followed by a ninth clock. The block never drives the data line, and it ignores whatever value the data line holds during that ninth clock.

A destination register changes only when its whole 32-bit word has arrived. At that moment a one-cycle strobe for that register pulses. A transfer that stops early, or that carries the wrong device address or an unknown function byte, changes nothing. A 2-bit preset input can hold the control word at one of three fixed values, so the surrounding chip can run without a bus master. While a preset is selected, bus writes to the control word are refused.

Top module: `serialRegLoader`

## Requirements
- R1: After reset, `ccWord` is 0x00000000, `ctrlWord` is 0xC0000000, and both strobes are low.
- R2: A falling data edge while the clock is high begins a transfer, and it does so even in the middle of another transfer. A rising data edge while the clock is high ends the transfer at once.
- R3: The first byte after a start is compared with the device address 0xB4, received most significant bit first. On a mismatch, everything up to the next start is ignored.
- R4: The second byte selects the destination: 0x00 selects `ccWord` and 0x03 selects `ctrlWord`. Any other value causes the rest of the transfer to be ignored.
- R5: The data line value during the ninth clock of each byte has no effect on the stored words.
- R6: The four data bytes are received most significant bit first, and the first byte lands in bits 31:24. For `ccWord`, bytes one and two (bits 31:16) are the line-21 caption pair and bytes three and four (bits 15:0) are the line-284 pair.
- R7: The destination word updates in one step, and its strobe is high for exactly one system clock. This happens on the ninth clock of the fourth data byte of the 54-clock write. A transfer that ends before that point leaves both words unchanged and raises no strobe.
- R8: A pulse on either bus line lasting fewer than FILT_LEN system clocks (default 3) is rejected. It neither clocks a bit nor forms a start or stop.
- R9: While `presetSel` is non-zero, `ctrlWord` takes a fixed value one cycle later: 1 gives 0xC8000000, 2 gives 0xD0000000 and 3 gives 0xDC0C0000. Bus writes to `ctrlWord` then have no effect and raise no strobe. With `presetSel` at 0, the last value is held and the bus controls the word.
- R10: Bytes after the fourth data byte are ignored until the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line, asynchronous |
| sdaIn | input | 1 | Bus data line, asynchronous |
| presetSel | input | 2 | Fixed control-word selection; 0 hands the word to the bus |
| ccWord | output | 32 | Closed-caption data word |
| ctrlWord | output | 32 | Control word |
| ccStrobe | output | 1 | One-cycle pulse when `ccWord` is loaded from the bus |
| ctrlStrobe | output | 1 | One-cycle pulse when `ctrlWord` is loaded from the bus |

## Verification
On every cycle, the embedded assertions check four things. The filter only ever settles to a level the synchronised line has held. A stop always returns the receiver to idle. At most one destination commits at a time. Neither word changes without its strobe, except for preset loads, and a selected preset forces its constant and blocks the control strobe.

Some behaviours need whole transfers and are shown only by the bench's scenarios. These are the bit and byte order, address and function rejection, immunity to the ninth-clock data value, the effect of early stops and repeated starts, excess bytes, and glitch rejection inside a live transfer.

// File: rtl/serialRegLoader_pkg.sv
package serialRegLoader_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEVICE,
    ST_FUNC,
    ST_DATA,
    ST_SKIP
  } rxState_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic shiftEn;
    logic bitVal;
    logic loadByte;
    logic commitCc;
    logic commitCtrl;
  } loadCtl_t;

  localparam logic [31:0] CTRL_RESET_WORD = 32'hC000_0000;
  localparam logic [31:0] PRESET_WORD_1   = 32'hC800_0000;
  localparam logic [31:0] PRESET_WORD_2   = 32'hD000_0000;
  localparam logic [31:0] PRESET_WORD_3   = 32'hDC0C_0000;

  function automatic logic [31:0] presetWord(input logic [1:0] sel);
    logic [31:0] w;
    case (sel)
      2'd1:    w = PRESET_WORD_1;
      2'd2:    w = PRESET_WORD_2;
      2'd3:    w = PRESET_WORD_3;
      default: w = CTRL_RESET_WORD;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/serialRegLoader_filter.sv
module serialRegLoader_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic lineOut
);
  localparam int CNT_W = $clog2(FILT_LEN + 1);

  logic syncA, syncB;
  logic [CNT_W-1:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b1;
      syncB <= 1'b1;
    end else begin
      syncA <= lineIn;
      syncB <= syncA;
    end
  end

  // the output follows only after FILT_LEN consecutive differing samples
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineOut <= 1'b1;
      runCnt  <= '0;
    end else if (syncB == lineOut) begin
      runCnt <= '0;
    end else if (runCnt == CNT_W'(FILT_LEN - 1)) begin
      lineOut <= syncB;
      runCnt  <= '0;
    end else begin
      runCnt <= runCnt + 1'b1;
    end
  end

  // R8: a new filtered level is one the synchroniser presented
  a_r8_filter_settles: assert property (@(posedge clk) disable iff (!rstN)
    (lineOut != $past(lineOut)) |-> ($past(syncB) == lineOut));

endmodule

// File: rtl/serialRegLoader_ctrl.sv
module serialRegLoader_ctrl
  import serialRegLoader_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          BYTE_W    = 8,
  parameter logic [7:0]  DEV_ADDR  = 8'hB4,
  parameter logic [7:0]  CC_FUNC   = 8'h00,
  parameter logic [7:0]  CTRL_FUNC = 8'h03
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclF,
  input  logic              sdaF,
  input  logic [BYTE_W-1:0] byteIn,
  output loadCtl_t          ctl
);
  localparam int NBYTES = DATA_W / BYTE_W;
  localparam int BIT_W  = $clog2(BYTE_W + 1);
  localparam int BYTE_CW = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [BIT_W-1:0]   ACK_BIT   = BIT_W'(BYTE_W);
  localparam logic [BYTE_CW-1:0] LAST_BYTE = BYTE_CW'(NBYTES - 1);

  rxState_t             state;
  logic                 sclQ, sdaQ;
  logic [BIT_W-1:0]     bitCnt;
  logic [BYTE_CW-1:0]   byteCnt;
  logic                 bankCtrl;

  logic startDet, stopDet, sclRise, activeSt, ackClk;

  assign startDet = sclF && sclQ && sdaQ && !sdaF;
  assign stopDet  = sclF && sclQ && !sdaQ && sdaF;
  assign sclRise  = sclF && !sclQ;
  assign activeSt = (state == ST_DEVICE) || (state == ST_FUNC) || (state == ST_DATA);
  assign ackClk   = sclRise && activeSt && (bitCnt == ACK_BIT);

  always_comb begin
    ctl.shiftEn    = sclRise && activeSt && (bitCnt != ACK_BIT);
    ctl.bitVal     = sdaF;
    ctl.loadByte   = ackClk && (state == ST_DATA) && (byteCnt != LAST_BYTE);
    ctl.commitCc   = ackClk && (state == ST_DATA) && (byteCnt == LAST_BYTE) && !bankCtrl;
    ctl.commitCtrl = ackClk && (state == ST_DATA) && (byteCnt == LAST_BYTE) && bankCtrl;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
    end else begin
      sclQ <= sclF;
      sdaQ <= sdaF;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      byteCnt  <= '0;
      bankCtrl <= 1'b0;
    end else if (startDet) begin
      state   <= ST_DEVICE;
      bitCnt  <= '0;
      byteCnt <= '0;
    end else if (stopDet) begin
      state <= ST_IDLE;
    end else if (sclRise && activeSt) begin
      if (bitCnt != ACK_BIT) begin
        bitCnt <= bitCnt + 1'b1;
      end else begin
        bitCnt <= '0;
        case (state)
          ST_DEVICE: state <= (byteIn == DEV_ADDR) ? ST_FUNC : ST_SKIP;
          ST_FUNC: begin
            if (byteIn == CC_FUNC) begin
              state    <= ST_DATA;
              bankCtrl <= 1'b0;
            end else if (byteIn == CTRL_FUNC) begin
              state    <= ST_DATA;
              bankCtrl <= 1'b1;
            end else begin
              state <= ST_SKIP;
            end
          end
          ST_DATA: begin
            if (byteCnt == LAST_BYTE) state <= ST_SKIP;
            byteCnt <= byteCnt + 1'b1;
          end
          default: state <= ST_SKIP;
        endcase
      end
    end
  end

  // R7: never two destinations at once
  a_r7_single_commit: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.commitCc, ctl.commitCtrl, ctl.loadByte}));

  // R2: a stop always ends the transfer
  a_r2_stop_idles: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> (state == ST_IDLE));

  // R10: after the last byte the receiver stays out of the data state until a start
  a_r10_skip_holds: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_SKIP) && !startDet) |=> (state != ST_DATA));

endmodule

// File: rtl/serialRegLoader_data.sv
module serialRegLoader_data
  import serialRegLoader_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  loadCtl_t          ctl,
  input  logic [1:0]        presetSel,
  output logic [BYTE_W-1:0] byteOut,
  output logic [DATA_W-1:0] ccWord,
  output logic [DATA_W-1:0] ctrlWord,
  output logic              ccStrobe,
  output logic              ctrlStrobe
);
  localparam int STAGE_W = DATA_W - BYTE_W;

  logic [BYTE_W-1:0]  byteShift;
  logic [STAGE_W-1:0] stage;
  logic [DATA_W-1:0]  fullWord;

  assign byteOut  = byteShift;
  assign fullWord = {stage, byteShift};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteShift <= '0;
      stage     <= '0;
    end else begin
      if (ctl.shiftEn)  byteShift <= {byteShift[BYTE_W-2:0], ctl.bitVal};
      if (ctl.loadByte) stage     <= {stage[STAGE_W-BYTE_W-1:0], byteShift};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ccWord   <= '0;
      ccStrobe <= 1'b0;
    end else begin
      ccStrobe <= ctl.commitCc;
      if (ctl.commitCc) ccWord <= fullWord;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlWord   <= DATA_W'(CTRL_RESET_WORD);
      ctrlStrobe <= 1'b0;
    end else begin
      ctrlStrobe <= ctl.commitCtrl && (presetSel == 2'd0);
      if (presetSel != 2'd0)  ctrlWord <= DATA_W'(presetWord(presetSel));
      else if (ctl.commitCtrl) ctrlWord <= fullWord;
    end
  end

  // R7: the caption word never changes without its strobe
  a_r7_cc_with_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (ccWord != $past(ccWord)) |-> ccStrobe);

  // R7: bus changes of the control word come with their strobe
  a_r7_ctrl_with_strobe: assert property (@(posedge clk) disable iff (!rstN)
    ((ctrlWord != $past(ctrlWord)) && ($past(presetSel) == 2'd0)) |-> ctrlStrobe);

  // R9: a selected preset forces its constant and blocks the strobe
  a_r9_preset_forces: assert property (@(posedge clk) disable iff (!rstN)
    (presetSel != 2'd0) |=> ((ctrlWord == DATA_W'(presetWord($past(presetSel)))) && !ctrlStrobe));

endmodule

// File: rtl/serialRegLoader.sv
module serialRegLoader
  import serialRegLoader_pkg::*;
#(
  parameter int         DATA_W    = 32,
  parameter int         BYTE_W    = 8,
  parameter int         FILT_LEN  = 3,
  parameter logic [7:0] DEV_ADDR  = 8'hB4,
  parameter logic [7:0] CC_FUNC   = 8'h00,
  parameter logic [7:0] CTRL_FUNC = 8'h03
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [1:0]        presetSel,
  output logic [DATA_W-1:0] ccWord,
  output logic [DATA_W-1:0] ctrlWord,
  output logic              ccStrobe,
  output logic              ctrlStrobe
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] rawLines, cleanLines;
  logic [BYTE_W-1:0] curByte;
  loadCtl_t          ctl;

  assign rawLines = {sdaIn, sclIn};

  for (genvar i = 0; i < NLINES; i++) begin : g_filt
    serialRegLoader_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rstN(rstN), .lineIn(rawLines[i]), .lineOut(cleanLines[i])
    );
  end

  serialRegLoader_ctrl #(
    .DATA_W(DATA_W), .BYTE_W(BYTE_W), .DEV_ADDR(DEV_ADDR),
    .CC_FUNC(CC_FUNC), .CTRL_FUNC(CTRL_FUNC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .sclF(cleanLines[0]), .sdaF(cleanLines[1]),
    .byteIn(curByte), .ctl(ctl)
  );

  serialRegLoader_data #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_data (
    .clk(clk), .rstN(rstN), .ctl(ctl), .presetSel(presetSel),
    .byteOut(curByte), .ccWord(ccWord), .ctrlWord(ctrlWord),
    .ccStrobe(ccStrobe), .ctrlStrobe(ctrlStrobe)
  );

endmodule

// File: tb/serialRegLoader_test.sv
module serialRegLoader_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclIn = 1'b1;
  logic sdaIn = 1'b1;
  logic [1:0] presetSel = 2'd0;
  logic [31:0] ccWord, ctrlWord;
  logic ccStrobe, ctrlStrobe;

  int nChecks = 0;
  int nFails = 0;
  localparam int HALF = 8;

  logic [32:0] expQ[$];
  logic prevCc = 1'b0, prevCtrl = 1'b0;

  always #10 clk = ~clk;

  serialRegLoader uut (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .presetSel(presetSel),
    .ccWord(ccWord), .ctrlWord(ctrlWord), .ccStrobe(ccStrobe), .ctrlStrobe(ctrlStrobe)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expectWrite(input bit isCtrl, input logic [31:0] val);
    expQ.push_back({isCtrl, val});
  endtask

  task automatic takeStrobe(input bit isCtrl, input logic [31:0] val);
    logic [32:0] e;
    if (expQ.size() == 0) begin
      check(1'b0, "R7 unexpected strobe", {31'd0, isCtrl}, 32'hFFFF_FFFF);
    end else begin
      e = expQ.pop_front();
      check(e[32] == isCtrl, "R4 destination", {31'd0, isCtrl}, {31'd0, e[32]});
      check(val == e[31:0], "R6 word value", val, e[31:0]);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (ccStrobe)   takeStrobe(1'b0, ccWord);
      if (ctrlStrobe) takeStrobe(1'b1, ctrlWord);
      if (ccStrobe && prevCc) check(1'b0, "R7 cc strobe width", 32'd2, 32'd1);
      if (ctrlStrobe && prevCtrl) check(1'b0, "R7 ctrl strobe width", 32'd2, 32'd1);
      prevCc   = ccStrobe;
      prevCtrl = ctrlStrobe;
    end
  end

  task automatic waitClk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic busStart();
    sdaIn = 1'b1; waitClk(HALF);
    sclIn = 1'b1; waitClk(HALF);
    sdaIn = 1'b0; waitClk(HALF);
    sclIn = 1'b0; waitClk(HALF);
  endtask

  task automatic busStop();
    sdaIn = 1'b0; waitClk(HALF);
    sclIn = 1'b1; waitClk(HALF);
    sdaIn = 1'b1; waitClk(HALF);
  endtask

  // glitch: short scl high pulse in the low phase, short sda low pulse in the high phase
  task automatic busBit(input bit v, input bit glitch);
    sdaIn = v; waitClk(HALF / 2);
    if (glitch) begin sclIn = 1'b1; waitClk(2); sclIn = 1'b0; end
    waitClk(HALF / 2);
    sclIn = 1'b1; waitClk(HALF / 2);
    if (glitch && v) begin sdaIn = 1'b0; waitClk(2); sdaIn = 1'b1; end
    waitClk(HALF / 2);
    sclIn = 1'b0; waitClk(2);
  endtask

  task automatic busByte(input logic [7:0] b, input bit dummy, input bit glitch);
    for (int i = 7; i >= 0; i--) busBit(b[i], glitch);
    busBit(dummy, 1'b0);
  endtask

  task automatic writeTxn(input logic [7:0] dev, input logic [7:0] fn, input logic [31:0] w,
                          input int nData, input bit dummy, input bit glitch);
    busStart();
    busByte(dev, dummy, 1'b0);
    busByte(fn, ~dummy, 1'b0);
    for (int k = 0; k < nData; k++) begin
      logic [7:0] b;
      b = (k < 4) ? w[31 - 8*k -: 8] : 8'h5A;
      busByte(b, dummy ^ k[0], glitch && (k == 1));
    end
    busStop();
    waitClk(4);
  endtask

  initial begin
    waitClk(5);
    // R1 reset state
    check(ccWord == 32'h0, "R1 cc reset", ccWord, 32'h0);
    check(ctrlWord == 32'hC000_0000, "R1 ctrl reset", ctrlWord, 32'hC000_0000);
    check(!ccStrobe && !ctrlStrobe, "R1 strobes low", {30'd0, ccStrobe, ctrlStrobe}, 32'h0);
    rstN = 1'b1;
    waitClk(5);

    // R3 R4 R6: caption word, line-21 pair high, line-284 pair low
    expectWrite(1'b0, 32'h1122_3344);
    writeTxn(8'hB4, 8'h00, 32'h1122_3344, 4, 1'b0, 1'b0);
    check(ccWord[31:16] == 16'h1122, "R6 line21 pair", {16'd0, ccWord[31:16]}, 32'h1122);

    // R5: ninth clock held high, control word
    expectWrite(1'b1, 32'hA55A_0FF0);
    writeTxn(8'hB4, 8'h03, 32'hA55A_0FF0, 4, 1'b1, 1'b0);
    check(ctrlWord == 32'hA55A_0FF0, "R5 ninth clock ignored", ctrlWord, 32'hA55A_0FF0);

    // R3: wrong device address
    writeTxn(8'hB5, 8'h00, 32'hDEAD_BEEF, 4, 1'b0, 1'b0);
    check(ccWord == 32'h1122_3344, "R3 bad address ignored", ccWord, 32'h1122_3344);

    // R4: unknown function byte
    writeTxn(8'hB4, 8'h01, 32'hCAFE_F00D, 4, 1'b0, 1'b0);
    check(ccWord == 32'h1122_3344, "R4 bad function cc", ccWord, 32'h1122_3344);
    check(ctrlWord == 32'hA55A_0FF0, "R4 bad function ctrl", ctrlWord, 32'hA55A_0FF0);

    // R7: partial transfer ends in stop
    writeTxn(8'hB4, 8'h00, 32'h7777_7777, 3, 1'b0, 1'b0);
    check(ccWord == 32'h1122_3344, "R7 partial unchanged", ccWord, 32'h1122_3344);

    // R2: repeated start aborts a transfer, the new one completes
    busStart();
    busByte(8'hB4, 1'b0, 1'b0);
    busByte(8'h00, 1'b0, 1'b0);
    busByte(8'h99, 1'b0, 1'b0);
    sclIn = 1'b0;
    expectWrite(1'b0, 32'h5566_7788);
    writeTxn(8'hB4, 8'h00, 32'h5566_7788, 4, 1'b1, 1'b0);
    check(ccWord == 32'h5566_7788, "R2 restart recovers", ccWord, 32'h5566_7788);

    // R10: fifth byte ignored
    expectWrite(1'b0, 32'h0102_0304);
    writeTxn(8'hB4, 8'h00, 32'h0102_0304, 6, 1'b0, 1'b0);
    check(ccWord == 32'h0102_0304, "R10 extra bytes ignored", ccWord, 32'h0102_0304);

    // R8: short glitches on both lines inside byte two
    expectWrite(1'b0, 32'h9ABC_DEF0);
    writeTxn(8'hB4, 8'h00, 32'h9ABC_DEF0, 4, 1'b0, 1'b1);
    check(ccWord == 32'h9ABC_DEF0, "R8 glitches rejected", ccWord, 32'h9ABC_DEF0);

    // R9: presets
    presetSel = 2'd1; waitClk(2);
    check(ctrlWord == 32'hC800_0000, "R9 preset 1", ctrlWord, 32'hC800_0000);
    presetSel = 2'd3; waitClk(2);
    check(ctrlWord == 32'hDC0C_0000, "R9 preset 3", ctrlWord, 32'hDC0C_0000);
    writeTxn(8'hB4, 8'h03, 32'h1234_5678, 4, 1'b0, 1'b0);
    check(ctrlWord == 32'hDC0C_0000, "R9 bus blocked", ctrlWord, 32'hDC0C_0000);
    presetSel = 2'd2; waitClk(2);
    check(ctrlWord == 32'hD000_0000, "R9 preset 2", ctrlWord, 32'hD000_0000);
    presetSel = 2'd0; waitClk(3);
    check(ctrlWord == 32'hD000_0000, "R9 held after release", ctrlWord, 32'hD000_0000);
    expectWrite(1'b1, 32'h1234_5678);
    writeTxn(8'hB4, 8'h03, 32'h1234_5678, 4, 1'b0, 1'b0);
    check(ctrlWord == 32'h1234_5678, "R9 bus control back", ctrlWord, 32'h1234_5678);

    waitClk(10);
    check(expQ.size() == 0, "R7 all strobes seen", expQ.size(), 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule